// File: doc/BRIEF.md
# Byte-Wide NAND Flash Bridge with On-the-Fly ECC

This block sits between a simple CPU register bus and the raw pins of a NAND flash device. Software drives the flash by writing a control register, whose bits go straight out as the chip-enable, command-latch, address-latch and write-protect pins. It moves command, address and data bytes through a data port, and each access to that port produces one write or read strobe toward the device. The control register also reads back the device's live ready/busy line.

Every byte that crosses the data port, in either direction, is folded into a Hamming-style error-correction accumulator. The accumulator keeps a byte counter, paired line-parity bits indexed by the counter bits, and paired column-parity bits over groups of bit positions. Software reads the line parity through two registers that interleave the even and odd halves, reads the column parity and the low byte of the counter, and clears all of them by writing any value to a dedicated offset.

A 32-bit read of the data port fetches two bytes from the device on consecutive cycles. The first byte lands in bits 7:0 and the second in bits 23:16. The bridge holds `bus_busy` high during the second cycle and accepts no new request while it is high.

Top module: `nand_bridge`

## Requirements
- R1: After synchronous reset all flash pin outputs are low, no strobe is active, `bus_rvalid` is low, and the counter, line-parity and column-parity registers read zero.
- R2: A write to offset 0x18 stores `bus_wdata[7:0]` with bit 5 forced to zero. From the next cycle `nand_ce` equals bit 0 OR bit 4, `nand_cle` equals bit 1, `nand_ale` equals bit 2 and `nand_wp` equals bit 3.
- R3: A read of offset 0x18 returns the stored byte with bit 5 replaced by the level of `nand_rb` in the request cycle.
- R4: A write to offset 0x14 pulses `nand_wstb` in the request cycle with `nand_dout` equal to `bus_wdata[7:0]`, and a word write sends only that low byte. A byte read of 0x14 pulses `nand_rstb` in the request cycle. One cycle later `bus_rvalid` is high with `nand_din` in bits 7:0 and zero above.
- R5: Each byte written or read through 0x14 increments the byte counter by one. Offset 0x0C returns the counter's low 8 bits, which wrap from 255 to 0.
- R6: For byte index n (the counter value before the byte) and byte parity p (XOR of its 8 bits), line bit i of the even half accumulates p when bit i of n is 0, and of the odd half when it is 1. Offset 0x00 places even bits 0..3 at positions 0,2,4,6 and odd bits 0..3 at 1,3,5,7. Offset 0x04 does the same for bits 4..7.
- R7: Offset 0x08 returns six column-parity bits with bits 7:6 zero. Bit 2k is the XOR, over all accumulated bytes, of the data bits whose position has bit k clear, and bit 2k+1 of those whose position has bit k set (k = 0,1,2).
- R8: A write of any value to offset 0x10 clears the counter and both parity sets. A read of 0x10 returns zero.
- R9: A word read of 0x14 strobes `nand_rstb` in the request cycle and again in the following cycle, with `bus_busy` high in that following cycle. One cycle later `bus_rvalid` is high with the first byte in bits 7:0, the second in 23:16, other bits zero. Both bytes enter the accumulator in order.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x14 or 0x18 returns zero. A write to such an offset produces no strobe and leaves the pins, the control register and the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data returned this cycle |
| bus_busy | output | 1 | Second half of a word read in progress |
| nand_ce | output | 1 | Flash chip enable (active high) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp | output | 1 | Write protect |
| nand_dout | output | 8 | Byte to the flash |
| nand_wstb | output | 1 | Write strobe, one per byte sent |
| nand_rstb | output | 1 | Read strobe; the device advances after the edge |
| nand_din | input | 8 | Byte from the flash, presented while `nand_rstb` is high |
| nand_rb | input | 1 | Flash ready/busy level |

## Verification
The assertions assume that no request is raised while `bus_busy` is high, and the checker flags any request made then. They also assume that the device holds its current byte on `nand_din` while a read strobe is high, and moves to the next byte only after the edge. The bench's device model serves bytes from a table indexed by a pointer that advances on each read strobe. Every bench task waits for the whole access, including the second half of a word read, before it raises the next request. This keeps the stimulus inside the one-request-at-a-time rule.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;

  // register window offsets
  localparam int OFS_LINE_LO = 'h00;
  localparam int OFS_LINE_HI = 'h04;
  localparam int OFS_COLUMN  = 'h08;
  localparam int OFS_COUNT   = 'h0C;
  localparam int OFS_CLEAR   = 'h10;
  localparam int OFS_DATA    = 'h14;
  localparam int OFS_CTRL    = 'h18;

  // control register bit positions
  localparam int CB_CE0  = 0;
  localparam int CB_CLE  = 1;
  localparam int CB_ALE  = 2;
  localparam int CB_WP   = 3;
  localparam int CB_CE1  = 4;
  localparam int CB_RDY  = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LINE_LO, SEL_LINE_HI, SEL_COLUMN,
    SEL_COUNT, SEL_CLEAR, SEL_DATA, SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
  parameter int DATA_W = 8,
  parameter int LP_W   = 8,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  feed,
  input  logic [DATA_W-1:0]     din,
  output logic [CNT_W-1:0]      count,
  output logic [LP_W-1:0]       lp_even,
  output logic [LP_W-1:0]       lp_odd,
  output logic [2*$clog2(DATA_W)-1:0] col_par
);
  localparam int GRPS = $clog2(DATA_W);

  logic                byte_par;
  logic [2*GRPS-1:0]   col_hit;
  logic [LP_W-1:0]     idx;

  assign byte_par = ^din;
  assign idx      = count[LP_W-1:0];

  // column contribution of this byte: per position group, XOR of bits
  // whose position has that address bit clear (even) or set (odd)
  always_comb begin
    col_hit = '0;
    for (int g = 0; g < GRPS; g++) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (((j >> g) & 1) == 1) col_hit[2*g+1] = col_hit[2*g+1] ^ din[j];
        else                     col_hit[2*g]   = col_hit[2*g]   ^ din[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count   <= '0;
      lp_even <= '0;
      lp_odd  <= '0;
      col_par <= '0;
    end else if (feed) begin
      count   <= count + 1'b1;
      lp_even <= lp_even ^ ({LP_W{byte_par}} & ~idx);
      lp_odd  <= lp_odd  ^ ({LP_W{byte_par}} &  idx);
      col_par <= col_par ^ col_hit;
    end
  end
endmodule

// File: rtl/nand_read_mux.sv
module nand_read_mux
  import nand_bridge_pkg::*;
#(
  parameter int LP_W  = 8,
  parameter int COL_W = 6
) (
  input  reg_sel_e          sel,
  input  logic [7:0]        ctl_q,
  input  logic              rb,
  input  logic [7:0]        din,
  input  logic [7:0]        count_lo,
  input  logic [LP_W-1:0]   lp_even,
  input  logic [LP_W-1:0]   lp_odd,
  input  logic [COL_W-1:0]  col_par,
  output logic [7:0]        rbyte
);
  localparam int HALF = LP_W / 2;

  logic [LP_W-1:0] line_lo, line_hi;

  // even half on even bit positions, odd half on odd positions
  for (genvar k = 0; k < HALF; k++) begin : g_ilv
    assign line_lo[2*k]   = lp_even[k];
    assign line_lo[2*k+1] = lp_odd[k];
    assign line_hi[2*k]   = lp_even[k+HALF];
    assign line_hi[2*k+1] = lp_odd[k+HALF];
  end

  always_comb begin
    rbyte = '0;
    case (sel)
      SEL_LINE_LO: rbyte = line_lo[7:0];
      SEL_LINE_HI: rbyte = line_hi[7:0];
      SEL_COLUMN:  rbyte = 8'(col_par);
      SEL_COUNT:   rbyte = count_lo;
      SEL_DATA:    rbyte = din;
      SEL_CTRL:    rbyte = {ctl_q[7:CB_RDY+1], rb, ctl_q[CB_RDY-1:0]};
      default:     rbyte = '0;
    endcase
  end
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LP_W   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_busy,
  output logic              nand_ce,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_wp,
  output logic [7:0]        nand_dout,
  output logic              nand_wstb,
  output logic              nand_rstb,
  input  logic [7:0]        nand_din,
  input  logic              nand_rb
);
  localparam int COL_W = 2 * $clog2(BYTE_W);

  reg_sel_e          sel;
  logic              acc, rd, wr, io_wr, io_rd, word_start, clr, feed;
  logic [7:0]        ctl_q, rbyte, feed_byte;
  logic [CNT_W-1:0]  count;
  logic [LP_W-1:0]   lp_even, lp_odd;
  logic [COL_W-1:0]  col_par;
  logic              busy_q;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[31:8], count[CNT_W-1:8]};

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_LINE_LO): sel = SEL_LINE_LO;
      ADDR_W'(OFS_LINE_HI): sel = SEL_LINE_HI;
      ADDR_W'(OFS_COLUMN):  sel = SEL_COLUMN;
      ADDR_W'(OFS_COUNT):   sel = SEL_COUNT;
      ADDR_W'(OFS_CLEAR):   sel = SEL_CLEAR;
      ADDR_W'(OFS_DATA):    sel = SEL_DATA;
      ADDR_W'(OFS_CTRL):    sel = SEL_CTRL;
      default:              sel = SEL_NONE;
    endcase
  end

  assign acc        = bus_req && !busy_q;
  assign rd         = acc && !bus_we;
  assign wr         = acc &&  bus_we;
  assign io_wr      = wr && (sel == SEL_DATA);
  assign io_rd      = rd && (sel == SEL_DATA);
  assign word_start = io_rd && bus_word;
  assign clr        = wr && (sel == SEL_CLEAR);

  // strobes are combinational so a byte moves in the request cycle
  assign nand_wstb = io_wr;
  assign nand_dout = bus_wdata[7:0];
  assign nand_rstb = io_rd || busy_q;
  assign feed      = nand_wstb || nand_rstb;
  assign feed_byte = nand_wstb ? bus_wdata[7:0] : nand_din;
  assign bus_busy  = busy_q;

  // control register and registered flash pins
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      nand_ce  <= 1'b0;
      nand_cle <= 1'b0;
      nand_ale <= 1'b0;
      nand_wp  <= 1'b0;
    end else if (wr && sel == SEL_CTRL) begin
      ctl_q    <= bus_wdata[7:0] & ~(8'd1 << CB_RDY);
      nand_ce  <= bus_wdata[CB_CE0] | bus_wdata[CB_CE1];
      nand_cle <= bus_wdata[CB_CLE];
      nand_ale <= bus_wdata[CB_ALE];
      nand_wp  <= bus_wdata[CB_WP];
    end
  end

  nand_ecc_accum #(.DATA_W(BYTE_W), .LP_W(LP_W), .CNT_W(CNT_W)) u_ecc (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .feed    (feed),
    .din     (feed_byte),
    .count   (count),
    .lp_even (lp_even),
    .lp_odd  (lp_odd),
    .col_par (col_par)
  );

  nand_read_mux #(.LP_W(LP_W), .COL_W(COL_W)) u_mux (
    .sel      (sel),
    .ctl_q    (ctl_q),
    .rb       (nand_rb),
    .din      (nand_din),
    .count_lo (count[7:0]),
    .lp_even  (lp_even),
    .lp_odd   (lp_odd),
    .col_par  (col_par),
    .rbyte    (rbyte)
  );

  // read return path, two-phase for a word read of the data port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      bus_rvalid <= 1'b0;
      if (busy_q) begin
        bus_rdata[23:16] <= nand_din;
        busy_q           <= 1'b0;
        bus_rvalid       <= 1'b1;
      end else if (rd) begin
        bus_rdata <= {24'd0, rbyte};
        if (word_start) busy_q     <= 1'b1;
        else            bus_rvalid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk
  import nand_bridge_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_busy,
  input logic              nand_ce,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_wp,
  input logic              nand_wstb,
  input logic              nand_rstb
);
  logic ctl_wr, word_rd, other_rd;
  assign ctl_wr   = bus_req && bus_we && !bus_busy && bus_addr == ADDR_W'(OFS_CTRL);
  assign word_rd  = bus_req && !bus_we && !bus_busy && bus_word && bus_addr == ADDR_W'(OFS_DATA);
  assign other_rd = bus_req && !bus_we && !bus_busy && !word_rd;

  // R9: input rule, no request while the second half of a word read runs
  assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> !bus_req);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(nand_wstb && nand_rstb));

  assert_byte_read_ret_R4: assert property (@(posedge clk) disable iff (rst)
    other_rd |=> (bus_rvalid && bus_rdata[31:8] == 24'd0));

  assert_word_second_R9: assert property (@(posedge clk) disable iff (rst)
    word_rd |=> (bus_busy && nand_rstb && !bus_rvalid));

  assert_word_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> (bus_rvalid && bus_rdata[31:24] == 8'd0 && bus_rdata[15:8] == 8'd0));

  assert_pins_follow_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (nand_cle == $past(bus_wdata[CB_CLE]) && nand_ale == $past(bus_wdata[CB_ALE]) &&
                nand_wp == $past(bus_wdata[CB_WP]) &&
                nand_ce == ($past(bus_wdata[CB_CE0]) | $past(bus_wdata[CB_CE1]))));

  assert_pins_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable({nand_ce, nand_cle, nand_ale, nand_wp}));

  assert_no_wstb_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |-> !nand_wstb);
endmodule

bind nand_bridge nand_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .bus_busy(bus_busy), .nand_ce(nand_ce),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_wp(nand_wp),
  .nand_wstb(nand_wstb), .nand_rstb(nand_rstb)
);

// File: tb/tb_nand_bridge.sv
module tb_nand_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid, bus_busy;
  logic          nand_ce, nand_cle, nand_ale, nand_wp;
  logic [7:0]    nand_dout, nand_din;
  logic          nand_wstb, nand_rstb;
  logic          nand_rb = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bridge #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_busy(bus_busy), .nand_ce(nand_ce),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_wp(nand_wp),
    .nand_dout(nand_dout), .nand_wstb(nand_wstb), .nand_rstb(nand_rstb),
    .nand_din(nand_din), .nand_rb(nand_rb)
  );

  // flash device model: byte table, pointer advances after each read strobe
  logic [7:0] flash_mem [256];
  logic [7:0] rptr = 8'd0;
  assign nand_din = flash_mem[rptr];
  always @(posedge clk) if (nand_rstb) rptr <= rptr + 8'd1;

  // reference accumulator built from the requirements
  int unsigned m_cnt;
  logic [7:0]  m_even, m_odd;
  logic [5:0]  m_col;
  logic [7:0]  m_ctl;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    m_cnt = 0; m_even = '0; m_odd = '0; m_col = '0;
  endtask

  task automatic m_feed(input logic [7:0] b);
    logic p;
    logic [7:0] n;
    p = ^b;
    n = 8'(m_cnt);
    for (int i = 0; i < 8; i++) begin
      if (n[i]) m_odd[i]  = m_odd[i]  ^ p;
      else      m_even[i] = m_even[i] ^ p;
    end
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 8; j++) begin
        if (((j >> k) & 1) == 1) m_col[2*k+1] = m_col[2*k+1] ^ b[j];
        else                     m_col[2*k]   = m_col[2*k]   ^ b[j];
      end
    m_cnt++;
  endtask

  function automatic logic [7:0] ilv(input logic [3:0] e, input logic [3:0] o);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k] = e[k]; r[2*k+1] = o[k];
    end
    return r;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input bit w);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
    #1;
    if (a == AW'('h14)) begin
      chk(nand_wstb && nand_dout == d[7:0], "R4 write strobe/data", {23'd0, nand_wstb, nand_dout}, {23'd0, 1'b1, d[7:0]});
      m_feed(d[7:0]);
    end else begin
      chk(!nand_wstb && !nand_rstb, "R10 no strobe on non-data write", {30'd0, nand_wstb, nand_rstb}, 32'd0);
    end
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_word = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input bit w, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_word = w; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0; bus_word = 1'b0;
    if (w && a == AW'('h14)) begin
      chk(bus_busy && nand_rstb && !bus_rvalid, "R9 second strobe with busy", {29'd0, bus_busy, nand_rstb, bus_rvalid}, 32'd6);
      @(negedge clk);
    end
    chk(bus_rvalid, "R4 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic read_data(input bit w, input string tag);
    logic [31:0] got, exp;
    logic [7:0] b0, b1;
    b0 = flash_mem[rptr];
    b1 = flash_mem[8'(rptr + 8'd1)];
    bus_read(AW'('h14), w, got);
    if (w) begin
      exp = {8'd0, b1, 8'd0, b0};
      m_feed(b0); m_feed(b1);
    end else begin
      exp = {24'd0, b0};
      m_feed(b0);
    end
    chk(got == exp, tag, got, exp);
  endtask

  task automatic check_ecc(input string tag);
    logic [31:0] got;
    bus_read(AW'('h0C), 1'b0, got);
    chk(got == 32'(m_cnt & 255), {"R5 counter ", tag}, got, 32'(m_cnt & 255));
    bus_read(AW'('h00), 1'b0, got);
    chk(got == {24'd0, ilv(m_even[3:0], m_odd[3:0])}, {"R6 line lo ", tag}, got, {24'd0, ilv(m_even[3:0], m_odd[3:0])});
    bus_read(AW'('h04), 1'b0, got);
    chk(got == {24'd0, ilv(m_even[7:4], m_odd[7:4])}, {"R6 line hi ", tag}, got, {24'd0, ilv(m_even[7:4], m_odd[7:4])});
    bus_read(AW'('h08), 1'b0, got);
    chk(got == {26'd0, m_col}, {"R7 column ", tag}, got, {26'd0, m_col});
  endtask

  task automatic ctl_write_check(input logic [7:0] v);
    logic [31:0] got;
    logic [3:0] exp_pins;
    bus_write(AW'('h18), {24'hA5A5A5, v}, 1'b0);
    m_ctl = v & 8'hDF;
    exp_pins = {v[0] | v[4], v[1], v[2], v[3]};
    chk({nand_ce, nand_cle, nand_ale, nand_wp} == exp_pins, "R2 pins after control write",
        {28'd0, nand_ce, nand_cle, nand_ale, nand_wp}, {28'd0, exp_pins});
    nand_rb = 1'($urandom % 2);
    bus_read(AW'('h18), 1'b0, got);
    chk(got == {24'd0, m_ctl | (8'(nand_rb) << 5)}, "R3 control readback with live ready",
        got, {24'd0, m_ctl | (8'(nand_rb) << 5)});
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [AW-1:0] bad_addrs [5];
    bad_addrs[0] = AW'('h1C); bad_addrs[1] = AW'('h20); bad_addrs[2] = AW'('h3C);
    bad_addrs[3] = AW'('h02); bad_addrs[4] = AW'('h15);
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) flash_mem[i] = 8'((i * 37 + 5) ^ (i >> 3));
    m_clear();
    m_ctl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk({nand_ce, nand_cle, nand_ale, nand_wp, nand_wstb, nand_rstb, bus_rvalid} == 7'd0,
        "R1 outputs after reset", {25'd0, nand_ce, nand_cle, nand_ale, nand_wp, nand_wstb, nand_rstb, bus_rvalid}, 32'd0);
    check_ecc("after reset R1");
    nand_rb = 1'b1;
    bus_read(AW'('h18), 1'b0, got);
    chk(got == 32'h20, "R1 R3 control after reset", got, 32'h20);

    // R2 R3 directed control patterns
    ctl_write_check(8'hFF);
    ctl_write_check(8'h10);
    ctl_write_check(8'h01);
    ctl_write_check(8'h06);
    ctl_write_check(8'h00);

    // R4 R9 directed data transfers
    bus_write(AW'('h14), 32'h0000_0080, 1'b0);
    bus_write(AW'('h14), 32'hDEAD_BE0F, 1'b1);   // word write sends low byte only
    read_data(1'b0, "R4 byte read");
    read_data(1'b1, "R9 word read packing");
    check_ecc("directed R5 R6 R7");

    // R8 clear with arbitrary value, then clear read returns zero
    bus_write(AW'('h10), 32'h1234_5678, 1'b0);
    m_clear();
    check_ecc("after clear R8");
    bus_read(AW'('h10), 1'b0, got);
    chk(got == 32'd0, "R8 clear offset reads zero", got, 32'd0);

    // R5 counter wrap past 255
    for (int i = 0; i < 260; i++) bus_write(AW'('h14), 32'($urandom), 1'b0);
    check_ecc("after wrap R5");

    // R10 unmapped offsets
    for (int i = 0; i < 5; i++) begin
      bus_write(bad_addrs[i], 32'hFFFF_FFFF, 1'b0);
      bus_read(bad_addrs[i], 1'b0, got);
      chk(got == 32'd0, "R10 unmapped read zero", got, 32'd0);
    end
    chk({nand_ce, nand_cle, nand_ale, nand_wp} == 4'd0, "R10 pins untouched", {28'd0, nand_ce, nand_cle, nand_ale, nand_wp}, 32'd0);
    check_ecc("after unmapped R10");

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0, 1, 2: bus_write(AW'('h14), 32'($urandom), 1'($urandom % 2));
        3, 4:    read_data(1'b0, "R4 random byte read");
        5:       read_data(1'b1, "R9 random word read");
        6:       check_ecc("random");
        7: if ($urandom % 4 == 0) begin
             bus_write(AW'('h10), 32'($urandom), 1'b0);
             m_clear();
           end
        8: begin
             int k;
             k = int'($urandom % 5);
             if ($urandom % 2 == 1) bus_write(bad_addrs[k], 32'($urandom), 1'b0);
             else begin
               bus_read(bad_addrs[k], 1'($urandom % 2), got);
               chk(got == 32'd0, "R10 random unmapped read", got, 32'd0);
             end
           end
        default: ctl_write_check(8'($urandom));
      endcase
    end
    check_ecc("final");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule